// File: doc/BRIEF.md
# Scale Factor Sample Reconstructor

This block rebuilds a full-width audio sample from a transmitted word that has been range-compressed. The word has two parts. The upper field has already passed error correction. The lower field was sent without protection. The block joins the two fields into one signed working word. It then moves that word down by a number of bit positions set by a decoded scale factor. The bit positions freed at the top are filled with copies of the sign. The top bits of the result form the sample.

A last stage re-codes the sample into one of four number formats for the converter that follows. The block takes one word per input strobe and produces one registered sample one clock later. It holds no other state. Error correction of the fields and of the scale factor, and any voting, happen upstream.

Top module: `sfr_recon`

## Requirements
- R1: While reset (`rst_n` low) is applied, `out_valid` is 0 and `out_sample` is 0.
- R2: `out_valid` is high in exactly those cycles that follow a cycle with `in_valid` high, so every accepted word yields one sample with a latency of one clock.
- R3: The working word is `{in_prot, in_raw}`. The protected field occupies the upper 11 bits, and bit 13 is the sign.
- R4: With scale factor 7 and two's complement coding, the sample is the working word in bits 15..2, and bits 1..0 are zero.
- R5: A scale factor `s` moves the working word down by `7 - s` positions. Scale factor 0 gives the largest shift (7) and the smallest output range.
- R6: Every bit position freed at the top by the shift carries the working word's sign bit. The result is a zero fill for positive words and a one fill for negative words.
- R7: `in_fmt` = 2'b11 gives the two's complement sample `y` unchanged.
- R8: `in_fmt` = 2'b10 gives the bitwise complement of `y`.
- R9: `in_fmt` = 2'b01 gives offset binary, which is `y` with bit 15 inverted and bits 14..0 unchanged.
- R10: `in_fmt` = 2'b00 gives the bitwise complement of the offset binary code, which is `y` with bits 14..0 inverted and bit 15 unchanged.
- R11: In a cycle where `in_valid` is low, `out_sample` keeps its value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word strobe |
| in_prot | input | 11 | Error-corrected upper field of the word |
| in_raw | input | 3 | Unprotected lower field of the word |
| in_scale | input | 3 | Decoded scale factor (7 = no shift) |
| in_fmt | input | 2 | Output coding select |
| out_valid | output | 1 | Sample strobe, one clock after `in_valid` |
| out_sample | output | 16 | Reconstructed and re-coded sample |

## Verification
The bench builds the block with its default widths: an 11-bit protected field, a 3-bit raw field, a 3-bit scale factor and a 16-bit sample. It uses the stage-per-bit shifter variant. With these values, all eight shift distances can be reached, including the full seven-position sign fill. The bench sweeps every scale factor against every coding with both positive and negative words. It runs back-to-back strobes and also idle gaps in which the inputs change.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
   // Output coding select; the encoding is visible on the in_fmt port.
   typedef enum logic [1:0] {
      FMT_OBIN_INV = 2'b00,
      FMT_OBIN     = 2'b01,
      FMT_TC_INV   = 2'b10,
      FMT_TC       = 2'b11
   } sfr_fmt_e;
endpackage

// File: rtl/sfr_join.sv
module sfr_join #(
   parameter int PROT_W = 11,
   parameter int RAW_W  = 3,
   localparam int WORD_W = PROT_W + RAW_W
) (
   input  logic [PROT_W-1:0] prot,
   input  logic [RAW_W-1:0]  raw,
   output logic [WORD_W-1:0] word
);
   // Protected field on top, raw field below (R3)
   assign word = {prot, raw};
endmodule

// File: rtl/sfr_shift.sv
module sfr_shift #(
   parameter int WORD_W    = 14,
   parameter int SF_W      = 3,
   parameter int OUT_W     = 16,
   parameter bit LOG_SHIFT = 1'b1,
   localparam int MAX_SHIFT = (1 << SF_W) - 1,
   localparam int ACC_W     = WORD_W + MAX_SHIFT
) (
   input  logic [WORD_W-1:0] word,
   input  logic [SF_W-1:0]   amount,
   output logic [OUT_W-1:0]  res
);
   logic signed [ACC_W-1:0] acc_in;
   logic signed [ACC_W-1:0] acc_out;

   assign acc_in = {word, {MAX_SHIFT{1'b0}}};

   generate
      if (LOG_SHIFT) begin : g_stages
         logic signed [ACC_W-1:0] st [0:SF_W];
         assign st[0] = acc_in;
         for (genvar k = 0; k < SF_W; k++) begin : g_stage
            assign st[k+1] = amount[k] ? (st[k] >>> (1 << k)) : st[k];
         end
         assign acc_out = st[SF_W];
      end else begin : g_flat
         assign acc_out = acc_in >>> amount;
      end
   endgenerate

   assign res = acc_out[ACC_W-1 -: OUT_W];

   // The sign of the sample always follows the sign of the word (R6)
   always_comb begin
      p_sign_r6: assert (res[OUT_W-1] == word[WORD_W-1])
         else $error("sign fill broken");
   end
endmodule

// File: rtl/sfr_code.sv
module sfr_code
   import sfr_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [W-1:0] tc,
   input  logic [1:0]   fmt,
   output logic [W-1:0] code
);
   always_comb begin
      unique case (sfr_fmt_e'(fmt))
         FMT_TC:       code = tc;
         FMT_TC_INV:   code = ~tc;
         FMT_OBIN:     code = {~tc[W-1], tc[W-2:0]};
         default:      code = {tc[W-1], ~tc[W-2:0]};
      endcase
   end

   // Offset binary keeps magnitude bits and flips only the top bit (R9)
   always_comb begin
      if (fmt == FMT_OBIN) begin
         p_offset_r9: assert ((code ^ tc) == {1'b1, {(W-1){1'b0}}})
            else $error("offset binary coding broken");
      end
   end
endmodule

// File: rtl/sfr_recon.sv
module sfr_recon #(
   parameter int PROT_W    = 11,
   parameter int RAW_W     = 3,
   parameter int SF_W      = 3,
   parameter int OUT_W     = 16,
   parameter bit LOG_SHIFT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [PROT_W-1:0] in_prot,
   input  logic [RAW_W-1:0]  in_raw,
   input  logic [SF_W-1:0]   in_scale,
   input  logic [1:0]        in_fmt,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_sample
);
   localparam int WORD_W    = PROT_W + RAW_W;
   localparam int MAX_SHIFT = (1 << SF_W) - 1;

   generate
      if (PROT_W < 1 || RAW_W < 0 || SF_W < 1) begin : g_bad_field
         $error("field widths out of range");
      end
      if (OUT_W < WORD_W) begin : g_bad_narrow
         $error("sample narrower than working word");
      end
      if (OUT_W > WORD_W + MAX_SHIFT) begin : g_bad_wide
         $error("sample wider than shifted word");
      end
   endgenerate

   logic [WORD_W-1:0] word;
   logic [SF_W-1:0]   amount;
   logic [OUT_W-1:0]  tc_sample;
   logic [OUT_W-1:0]  coded;

   sfr_join #(.PROT_W(PROT_W), .RAW_W(RAW_W)) u_join (
      .prot(in_prot), .raw(in_raw), .word(word)
   );

   // Largest scale factor means no shift (R5)
   assign amount = ~in_scale;

   sfr_shift #(.WORD_W(WORD_W), .SF_W(SF_W), .OUT_W(OUT_W),
               .LOG_SHIFT(LOG_SHIFT)) u_shift (
      .word(word), .amount(amount), .res(tc_sample)
   );

   sfr_code #(.W(OUT_W)) u_code (
      .tc(tc_sample), .fmt(in_fmt), .code(coded)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_sample <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_sample <= coded;
      end
   end

   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (out_valid == $past(in_valid)))
      else $error("strobe latency broken");

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(in_valid)) |-> $stable(out_sample))
      else $error("sample changed without strobe");

   generate
      if (OUT_W > WORD_W) begin : g_low_chk
         p_lowzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && out_valid && ($past(in_scale) == {SF_W{1'b1}})
             && ($past(in_fmt) == 2'b11))
            |-> (out_sample[OUT_W-WORD_W-1:0] == '0))
            else $error("unshifted sample has nonzero low bits");
      end
   endgenerate
endmodule

// File: tb/sfr_recon_test.sv
module sfr_recon_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [10:0] in_prot = '0;
   logic [2:0]  in_raw = '0;
   logic [2:0]  in_scale = '0;
   logic [1:0]  in_fmt = '0;
   logic        out_valid;
   logic [15:0] out_sample;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   logic [15:0] exp_q[$];
   string       tag_q[$];
   logic [15:0] last_exp = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sfr_recon uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_prot(in_prot),
      .in_raw(in_raw), .in_scale(in_scale), .in_fmt(in_fmt),
      .out_valid(out_valid), .out_sample(out_sample)
   );

   function automatic logic [15:0] model(input logic [10:0] p, input logic [2:0] r,
                                         input logic [2:0] sf, input logic [1:0] f);
      logic [13:0] w;
      longint v;
      logic [15:0] y;
      w = {p, r};
      v = longint'($signed(w)) * 4;
      v = v >>> (7 - int'(sf));
      y = v[15:0];
      case (f)
         2'b11: return y;
         2'b10: return ~y;
         2'b01: return {~y[15], y[14:0]};
         default: return {y[15], ~y[14:0]};
      endcase
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send(input logic [10:0] p, input logic [2:0] r, input logic [2:0] sf,
                       input logic [1:0] f, input string req);
      @(posedge clk); #2;
      in_prot = p; in_raw = r; in_scale = sf; in_fmt = f; in_valid = 1'b1;
      exp_q.push_back(model(p, r, sf, f));
      tag_q.push_back(req);
   endtask

   task automatic idle();
      @(posedge clk); #2;
      in_valid = 1'b0;
   endtask

   // Monitor: pops one expectation per output strobe (R2)
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            n_checks++; n_fail++;
            $display("FAIL R2: actual strobe expected none");
         end else begin
            string t;
            logic [15:0] e;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            last_exp = e;
            check(t, out_sample, e);
         end
      end
   end

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #3;
      check("R1 valid", {15'd0, out_valid}, 16'd0);
      check("R1 sample", out_sample, 16'd0);
      @(posedge clk); #2;
      rst_n = 1'b1;

      // R4, R3: raw field lands at bits 4..2, protected above
      send(11'd0, 3'b101, 3'd7, 2'b11, "R4 R3 raw field");
      send(11'h001, 3'b000, 3'd7, 2'b11, "R3 prot lsb");
      // R5, R6: maximal shift positive and negative
      send(11'h3FF, 3'b111, 3'd0, 2'b11, "R6 zero fill");
      send(11'h400, 3'b000, 3'd0, 2'b11, "R6 one fill");
      send(11'h555, 3'b010, 3'd4, 2'b11, "R5 mid shift");
      // R7..R10 on one negative word
      send(11'h6A3, 3'b011, 3'd6, 2'b11, "R7 two's complement");
      send(11'h6A3, 3'b011, 3'd6, 2'b10, "R8 complemented");
      send(11'h6A3, 3'b011, 3'd6, 2'b01, "R9 offset binary");
      send(11'h6A3, 3'b011, 3'd6, 2'b00, "R10 complemented offset");
      idle();

      // R11: inputs move while strobe is low
      repeat (2) @(posedge clk);
      #2;
      in_prot = 11'h123; in_scale = 3'd1; in_fmt = 2'b10;
      repeat (3) @(negedge clk);
      check("R11 hold", out_sample, last_exp);
      check("R2 no strobe", {15'd0, out_valid}, 16'd0);

      // Sweep: every scale factor against every coding, back to back
      for (int sf = 0; sf < 8; sf++) begin
         for (int f = 0; f < 4; f++) begin
            send(11'((sf * 173 + f * 389 + 5) % 2048), 3'((sf + f) % 8),
                 3'(sf), 2'(f), "R5 R6 sweep");
         end
      end
      idle();
      repeat (3) @(negedge clk);
      check("R2 drained", 16'(exp_q.size()), 16'd0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule